// File: doc/BRIEF.md
# Device Idle Timer Bank with SMI

This block keeps one countdown timer per watched device for legacy power management. Each timer watches the bus accesses reported on an observe port: an address, an I/O-or-memory flag and a one-cycle valid strobe. When an access falls inside the timer's window, the timer is reloaded with its programmed count. The timer counts down one step per tick pulse. When it reaches zero, it has found an idle device. It then sets a per-timer status bit and a shared top-level status bit, and it raises the system management interrupt output.

Timer 0 watches a fixed video memory window set by parameters. Every other timer has a programmable window, made of a base register and a control register that holds an address mask and a space select. Three global bits gate the whole bank: a power-management enable, an idle-timer enable and a mode select. Clearing the idle-timer enable freezes every timer at its current count. A register interface, with a write strobe and a combinational read, gives access to the enables, the counts, the windows, the live counter values and the write-one-to-clear status.

Top module: `idle_smi_bank`

## Requirements
- R1: After reset, the control register (offset 0), the status register (offset 2), every live counter and `smi_o` all read 0.
- R2: A timer decrements by one on each cycle with `tick` high when all of these hold: power management is on (control bit 0), idle timers are on (control bit 1), legacy mode is selected (control bit 2 = 0), and the timer's enable bit is set (offset 1, bit i). Writing the count register of timer i (offset 4+4i) loads both the programmed count and the live counter (readable at offset 7+4i).
- R3: When a running timer steps from 1 to 0, status bit i and top-level status bit 16 are set at that edge. `smi_o` is high while a set per-timer status bit has its timer enable set and power management is on.
- R4: An access reloads a programmable timer with its programmed count when (address & ~mask) equals the base, and the space matches. The base is at offset 5+4i. The window register at offset 6+4i holds the mask in bits 15:0 and the space in bit 16 (1 = memory, 0 = I/O). An access to the other space, or to an address outside the window, leaves the count unchanged.
- R5: Timer 0 is reloaded by memory accesses to 0xA000–0xBFFF. I/O accesses, and memory accesses outside that range, leave it unchanged.
- R6: While idle timers are off, the timers hold their counts, and accesses do not reload them. Turning idle timers back on resumes counting from the held value, with no reload.
- R7: With power management off, or with control bit 2 set (advanced mode), no timer counts down and no access reloads a timer.
- R8: Writing 1 to a status bit at offset 2 clears it. Bit i clears the per-timer bit and bit 16 clears the top-level bit. The top-level bit alone does not drive `smi_o`.
- R9: When a reload hit and the final decrement fall in the same cycle, the reload wins and no status bit is set.
- R10: A timer at zero does not count or expire, including one reloaded with a programmed count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | ADDR_W+1 | Register write data |
| reg_rdata | output | ADDR_W+1 | Register read data (combinational) |
| acc_vld | input | 1 | Observed bus access strobe |
| acc_mem | input | 1 | Observed access is memory (1) or I/O (0) |
| acc_addr | input | ADDR_W | Observed access address |
| tick | input | 1 | Countdown tick enable |
| smi_o | output | 1 | System management interrupt request |

## Verification
The hardest case to reach is the collision between a window hit and the final decrement. The bench sets this up by loading the live counter to 1 through the count register. It then drives a matching access and a tick pulse in the same cycle, and checks that the count returns to the programmed value with no status bit set. Freezing is reached by dropping the idle-timer enable between ticks. A matching access is then offered while frozen, and the live counter is read back before and after re-enabling, to show that no reload occurred.

// File: rtl/idle_smi_pkg.sv
package idle_smi_pkg;

  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL = 6'd0;
  localparam logic [REG_AW-1:0] OFS_TEN  = 6'd1;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'd2;

  // per-timer sub-offsets inside a 4-word slot starting at 4*(i+1)
  localparam logic [1:0] SUB_COUNT = 2'd0;
  localparam logic [1:0] SUB_BASE  = 2'd1;
  localparam logic [1:0] SUB_WIN   = 2'd2;
  localparam logic [1:0] SUB_LIVE  = 2'd3;

  typedef struct packed {
    logic adv_mode;
    logic idle_en;
    logic pm_en;
  } bank_ctrl_t;

endpackage

// File: rtl/idle_window.sv
module idle_window #(
  parameter int ADDR_W = 16
) (
  input  logic              strobe,
  input  logic              acc_mem,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic              win_mem,
  output logic              hit_o
);

  logic space_ok;
  logic addr_ok;

  assign space_ok = (acc_mem == win_mem);
  assign addr_ok  = ((acc_addr & ~win_mask) == win_base);
  assign hit_o    = strobe && space_ok && addr_ok;

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             hit,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    expire_o = 1'b0;
    if (ld_wr) begin
      cnt_d  = ld_val;
      cnt_en = 1'b1;
    end else if (run && hit) begin
      cnt_d  = reload_val;
      cnt_en = 1'b1;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_d    = cnt_q - CNT_W'(1);
      cnt_en   = 1'b1;
      expire_o = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(cnt_q)); // R6
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit && !ld_wr) |=> (cnt_q == $past(reload_val))); // R4
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0)); // R3
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ld_wr && (cnt_q == '0)) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/idle_status.sv
module idle_status #(
  parameter int N_DEV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] expire_i,
  input  logic             clr_wr,
  input  logic [N_DEV-1:0] clr_dev,
  input  logic             clr_top,
  output logic [N_DEV-1:0] stat_o,
  output logic             top_o
);

  logic [N_DEV-1:0] stat_q;
  logic [N_DEV-1:0] stat_d;
  logic             top_q;
  logic             top_d;
  logic             any_exp;

  assign any_exp = |expire_i;

  always_comb begin
    stat_d = stat_q;
    top_d  = top_q;
    if (clr_wr) begin
      stat_d = stat_d & ~clr_dev;
      top_d  = top_d & ~clr_top;
    end
    stat_d = stat_d | expire_i;
    top_d  = top_d | any_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      top_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      top_q  <= top_d;
    end
  end

  assign stat_o = stat_q;
  assign top_o  = top_q;

  AST_TOP_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    any_exp |=> top_q); // R3
  AST_TOP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_top && !any_exp) |=> !top_q); // R8
  AST_DEV_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|stat_q)) |-> top_q); // R3

endmodule

// File: rtl/idle_smi_bank.sv
module idle_smi_bank
  import idle_smi_pkg::*;
#(
  parameter int          N_DEV     = 3,
  parameter int          CNT_W     = 16,
  parameter int          ADDR_W    = 16,
  parameter bit          VID_FIXED = 1'b1,
  parameter logic [15:0] VID_BASE  = 16'hA000,
  parameter logic [15:0] VID_MASK  = 16'h1FFF,
  parameter bit          VID_MEM   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [ADDR_W:0]   reg_wdata,
  output logic [ADDR_W:0]   reg_rdata,
  input  logic              acc_vld,
  input  logic              acc_mem,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              tick,
  output logic              smi_o
);

  localparam int REG_W = ADDR_W + 1;
  localparam int TOP_BIT = REG_W - 1;

  initial begin
    if (N_DEV < 1 || N_DEV > 14) $error("N_DEV must lie in 1..14");
    if (CNT_W > REG_W) $error("CNT_W must not exceed register width");
  end

  bank_ctrl_t        ctrl_q;
  logic [N_DEV-1:0]  ten_q;
  logic              ctrl_wr;
  logic              ten_wr;
  logic              stat_wr;
  logic              run_all;

  logic [CNT_W-1:0]  prog_cnt [N_DEV];
  logic [CNT_W-1:0]  live_cnt [N_DEV];
  logic [ADDR_W-1:0] base_v   [N_DEV];
  logic [REG_W-1:0]  win_v    [N_DEV];
  logic [N_DEV-1:0]  expire;
  logic [N_DEV-1:0]  stat;
  logic              top_stat;

  assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  assign ten_wr  = reg_we && (reg_addr == OFS_TEN);
  assign stat_wr = reg_we && (reg_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= bank_ctrl_t'(reg_wdata[2:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q <= '0;
    end else if (ten_wr) begin
      ten_q <= reg_wdata[N_DEV-1:0];
    end
  end

  assign run_all = ctrl_q.pm_en && ctrl_q.idle_en && !ctrl_q.adv_mode;

  for (genvar g = 0; g < N_DEV; g++) begin : g_tmr
    logic             slot_sel;
    logic             cnt_wr;
    logic             hit;
    logic [CNT_W-1:0] count_q;

    assign slot_sel = reg_we && (reg_addr[5:2] == 4'(g + 1));
    assign cnt_wr   = slot_sel && (reg_addr[1:0] == SUB_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        count_q <= '0;
      end else if (cnt_wr) begin
        count_q <= reg_wdata[CNT_W-1:0];
      end
    end
    assign prog_cnt[g] = count_q;

    if (g == 0 && VID_FIXED) begin : g_video
      assign base_v[g] = ADDR_W'(VID_BASE);
      assign win_v[g]  = {VID_MEM, ADDR_W'(VID_MASK)};
    end else begin : g_prog
      logic [ADDR_W-1:0] base_q;
      logic [REG_W-1:0]  win_q;
      logic              base_wr;
      logic              win_wr;

      assign base_wr = slot_sel && (reg_addr[1:0] == SUB_BASE);
      assign win_wr  = slot_sel && (reg_addr[1:0] == SUB_WIN);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q <= '0;
        end else if (base_wr) begin
          base_q <= reg_wdata[ADDR_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          win_q <= '0;
        end else if (win_wr) begin
          win_q <= reg_wdata;
        end
      end

      assign base_v[g] = base_q;
      assign win_v[g]  = win_q;
    end

    idle_window #(.ADDR_W(ADDR_W)) u_win (
      .strobe   (acc_vld),
      .acc_mem  (acc_mem),
      .acc_addr (acc_addr),
      .win_base (base_v[g]),
      .win_mask (win_v[g][ADDR_W-1:0]),
      .win_mem  (win_v[g][ADDR_W]),
      .hit_o    (hit)
    );

    idle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_all && ten_q[g]),
      .tick       (tick),
      .hit        (hit),
      .ld_wr      (cnt_wr),
      .ld_val     (reg_wdata[CNT_W-1:0]),
      .reload_val (count_q),
      .cnt_o      (live_cnt[g]),
      .expire_o   (expire[g])
    );
  end

  idle_status #(.N_DEV(N_DEV)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .clr_wr   (stat_wr),
    .clr_dev  (reg_wdata[N_DEV-1:0]),
    .clr_top  (reg_wdata[TOP_BIT]),
    .stat_o   (stat),
    .top_o    (top_stat)
  );

  assign smi_o = ctrl_q.pm_en && (|(stat & ten_q));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) begin
      reg_rdata[2:0] = ctrl_q;
    end else if (reg_addr == OFS_TEN) begin
      reg_rdata[N_DEV-1:0] = ten_q;
    end else if (reg_addr == OFS_STAT) begin
      reg_rdata[N_DEV-1:0] = stat;
      reg_rdata[TOP_BIT]   = top_stat;
    end
    for (int i = 0; i < N_DEV; i++) begin
      if (reg_addr[5:2] == 4'(i + 1)) begin
        case (reg_addr[1:0])
          SUB_COUNT: reg_rdata[CNT_W-1:0]  = prog_cnt[i];
          SUB_BASE:  reg_rdata[ADDR_W-1:0] = base_v[i];
          SUB_WIN:   reg_rdata             = win_v[i];
          default:   reg_rdata[CNT_W-1:0]  = live_cnt[i];
        endcase
      end
    end
  end

  AST_SMI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> (|stat)); // R3
  AST_INERT_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_all) |-> (expire == '0)); // R7

endmodule

// File: tb/idle_smi_bank_tb.sv
module idle_smi_bank_tb;

  localparam int RW = 17;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [5:0]    reg_addr;
  logic [RW-1:0] reg_wdata;
  logic [RW-1:0] reg_rdata;
  logic          acc_vld;
  logic          acc_mem;
  logic [15:0]   acc_addr;
  logic          tick;
  logic          smi_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit            is_smi;
    logic [RW-1:0] exp;
    string         tag;
  } sb_item_t;

  sb_item_t sb[$];
  sb_item_t cur;

  idle_smi_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_vld(acc_vld),
    .acc_mem(acc_mem), .acc_addr(acc_addr), .tick(tick), .smi_o(smi_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      logic [RW-1:0] act;
      cur = sb.pop_front();
      act = cur.is_smi ? RW'(smi_o) : reg_rdata;
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [RW-1:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{is_smi: 1'b0, exp: e, tag: t});
  endtask

  task automatic chk_smi(input logic e, input string t);
    @(negedge clk);
    sb.push_back('{is_smi: 1'b1, exp: RW'(e), tag: t});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic access(input logic [15:0] a, input logic m, input logic t);
    @(negedge clk);
    acc_vld = 1'b1; acc_addr = a; acc_mem = m; tick = t;
    @(negedge clk);
    acc_vld = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_vld = 1'b0; acc_mem = 1'b0; acc_addr = '0; tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk_rd(6'd0, 17'h0, "R1 ctrl");
    chk_rd(6'd2, 17'h0, "R1 status");
    chk_rd(6'd7, 17'h0, "R1 live0");
    chk_smi(1'b0, "R1 smi");

    // R7 inert without pm_en, then in advanced mode
    wr(6'd8, 17'd5);
    wr(6'd1, 17'h7);
    wr(6'd0, 17'h2);
    ticks(3);
    chk_rd(6'd11, 17'd5, "R7 pm off no count");
    wr(6'd0, 17'h7);
    ticks(2);
    chk_rd(6'd11, 17'd5, "R7 adv mode no count");

    // R2 counting in legacy mode
    wr(6'd0, 17'h3);
    ticks(2);
    chk_rd(6'd11, 17'd3, "R2 countdown");

    // R4 window reloads
    wr(6'd9, 17'h0300);
    wr(6'd10, 17'h0000F);
    access(16'h0305, 1'b0, 1'b0);
    chk_rd(6'd11, 17'd5, "R4 io hit reload");
    ticks(1);
    chk_rd(6'd11, 17'd4, "R2 after reload");
    access(16'h0305, 1'b1, 1'b0);
    chk_rd(6'd11, 17'd4, "R4 wrong space ignored");
    access(16'h0315, 1'b0, 1'b0);
    chk_rd(6'd11, 17'd4, "R4 outside window ignored");

    // R6 freeze and resume
    wr(6'd0, 17'h1);
    ticks(3);
    chk_rd(6'd11, 17'd4, "R6 frozen");
    access(16'h0305, 1'b0, 1'b0);
    chk_rd(6'd11, 17'd4, "R6 no reload while frozen");
    wr(6'd0, 17'h3);
    chk_rd(6'd11, 17'd4, "R6 resume no reload");
    ticks(1);
    chk_rd(6'd11, 17'd3, "R6 resumed count");

    // R3 expiry
    ticks(3);
    chk_rd(6'd11, 17'd0, "R3 reached zero");
    chk_rd(6'd2, 17'h10002, "R3 status set");
    chk_smi(1'b1, "R3 smi high");
    ticks(2);
    chk_rd(6'd11, 17'd0, "R10 stays at zero");

    // R8 write-one-to-clear
    wr(6'd2, 17'h00002);
    chk_rd(6'd2, 17'h10000, "R8 dev bit cleared");
    chk_smi(1'b0, "R8 top alone no smi");
    wr(6'd2, 17'h10000);
    chk_rd(6'd2, 17'h0, "R8 top cleared");

    // R5 fixed video window on timer 0
    wr(6'd4, 17'd2);
    ticks(1);
    chk_rd(6'd7, 17'd1, "R5 video counting");
    access(16'hB123, 1'b1, 1'b0);
    chk_rd(6'd7, 17'd2, "R5 video hit");
    ticks(1);
    access(16'hA000, 1'b0, 1'b0);
    chk_rd(6'd7, 17'd1, "R5 io ignored");
    access(16'hC000, 1'b1, 1'b0);
    chk_rd(6'd7, 17'd1, "R5 outside ignored");
    ticks(1);
    chk_rd(6'd2, 17'h10001, "R3 timer0 status");
    chk_smi(1'b1, "R3 timer0 smi");
    wr(6'd1, 17'h6);
    chk_smi(1'b0, "R3 smi gated by enable");
    chk_rd(6'd2, 17'h10001, "R3 status kept");
    wr(6'd1, 17'h7);
    wr(6'd2, 17'h10001);
    chk_rd(6'd2, 17'h0, "R8 clear both");

    // R9 reload beats expiry
    wr(6'd8, 17'd1);
    access(16'h0301, 1'b0, 1'b1);
    chk_rd(6'd11, 17'd1, "R9 reload wins");
    chk_rd(6'd2, 17'h0, "R9 no status");
    ticks(1);
    chk_rd(6'd2, 17'h10002, "R9 later expiry");
    wr(6'd2, 17'h10002);

    // R10 zero count stays idle
    wr(6'd8, 17'd0);
    access(16'h0302, 1'b0, 1'b0);
    ticks(2);
    chk_rd(6'd11, 17'd0, "R10 zero count idle");
    chk_rd(6'd2, 17'h0, "R10 no expiry");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule